// File: doc/BRIEF.md
# Card Power-Up Initialization Sequencer

This block is the host-side controller that takes a MultiMediaCard in SPI mode from power-on to the ready state. It does not shift bits itself. It asks a separate link layer for each step and waits for that layer to report completion. The first request is a run of idle clocks with chip select high. After that it sends a software reset command. If enabled, it then reads the operating-conditions register and checks that register against the host's supply window. It then sends the operand-free operation-condition command again and again until the card reports that it has left the idle state.

One cycle of `start_i` in the idle state begins a run. The voltage-check enable, the voltage mask and the polling limit are captured at that moment. At the end of a run exactly one result flag is raised, and it stays up until the next accepted start:
- ready
- voltage mismatch
- polling timeout
- response error

Top module: `cardinit_seq`

## Requirements
- R1: After reset, busy, all four result flags, the wake request and the command strobe are low.
- R2: An accepted start first raises a one-cycle wake request with `wake_clks_o` at least 74. No command strobe appears before the link layer acknowledges it, and the wake request and the command strobe are never high together.
- R3: After the wake acknowledgement, the first command has index 0, argument 0 and check byte 0x95.
- R4: With the voltage check enabled, index 58 (argument 0) follows the reset command once. With it disabled, index 58 is never issued and the returned register contents have no effect.
- R5: The supply window is register bits 23:15, ANDed with `volt_mask_i` bits 8:0. When no bit is common, the run ends with the voltage-mismatch flag and index 1 is never issued.
- R6: Polling uses index 1 with argument 0. It is reissued as long as the response byte has bit 0 (idle) set and no other bit set.
- R7: A polling response of exactly 0x00 ends the run with the ready flag.
- R8: Any response byte with a bit among 7:1 set ends the run at once with the response-error flag. This applies to the reset, register-read and polling responses alike.
- R9: With polling limit L, at most max(L,1) index-1 commands are issued. If the last of them still reports idle, the run ends with the timeout flag.
- R10: `start_i` has no effect while busy.
- R11: At most one result flag is high at any time, and none is high while busy.
- R12: The enable, mask and limit are sampled on the accepted start. Later changes do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| start_i | input | 1 | Begin a run (taken only when not busy) |
| ocr_chk_en_i | input | 1 | Enable the register read and voltage check |
| volt_mask_i | input | 9 | Host supply window, one bit per register bit 23:15 |
| retry_lim_i | input | 16 | Polling limit (0 behaves as 1) |
| wake_req_o | output | 1 | One-cycle request for idle clocks with chip select high |
| wake_clks_o | output | 8 | Number of idle clocks requested |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_index_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_crc_o | output | 8 | Final command byte (check bits and end bit) |
| lnk_done_i | input | 1 | Link layer finished the current request |
| rsp_r1_i | input | 8 | First response byte, valid with lnk_done_i |
| rsp_data_i | input | 32 | Trailing 32-bit response word, valid with lnk_done_i |
| busy_o | output | 1 | Run in progress |
| ready_o | output | 1 | Card left idle |
| volt_err_o | output | 1 | Supply window mismatch |
| tmo_err_o | output | 1 | Polling limit reached |
| rsp_err_o | output | 1 | Error bit in a response byte |

## Verification
The assertions assume a well-behaved link layer. It raises `lnk_done_i` for a single cycle, only after a strobe, and at least one cycle after it. The response fields are meaningful only in that cycle. The bench plays the card and the link together. It answers every strobe after one to four cycles and never acknowledges without a pending request. It also puts stray `start_i` pulses only into the waiting periods, so that R10 is exercised without breaking these assumptions.

// File: rtl/cardinit_pkg.sv
package cardinit_pkg;

  localparam logic [5:0] IDX_GO_IDLE  = 6'd0;
  localparam logic [5:0] IDX_OP_COND  = 6'd1;
  localparam logic [5:0] IDX_READ_OCR = 6'd58;

  localparam logic [7:0] CRC_GO_IDLE  = 8'h95;
  localparam logic [7:0] CRC_FILLER   = 8'hFF;

  typedef enum logic [1:0] {
    CK_NONE,
    CK_GO_IDLE,
    CK_READ_OCR,
    CK_OP_COND
  } cmd_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE_REQ,
    ST_WAKE_WAIT,
    ST_RST_REQ,
    ST_RST_WAIT,
    ST_OCR_REQ,
    ST_OCR_WAIT,
    ST_POLL_REQ,
    ST_POLL_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_READY,
    RES_VOLT,
    RES_TMO,
    RES_RSP
  } result_e;

endpackage

// File: rtl/cardinit_cmd_fmt.sv
module cardinit_cmd_fmt
  import cardinit_pkg::*;
#(
  parameter int ARG_W = 32
) (
  input  cmd_kind_e        kind_i,
  output logic [5:0]       index_o,
  output logic [ARG_W-1:0] arg_o,
  output logic [7:0]       crc_o
);

  // every command of the power-up sequence carries a zero operand
  assign arg_o = '0;

  always_comb begin
    index_o = IDX_GO_IDLE;
    crc_o   = CRC_FILLER;
    unique case (kind_i)
      CK_GO_IDLE: begin
        index_o = IDX_GO_IDLE;
        crc_o   = CRC_GO_IDLE;
      end
      CK_READ_OCR: index_o = IDX_READ_OCR;
      CK_OP_COND:  index_o = IDX_OP_COND;
      default: begin
        index_o = IDX_GO_IDLE;
        crc_o   = CRC_FILLER;
      end
    endcase
  end

endmodule

// File: rtl/cardinit_retry_ctr.sv
module cardinit_retry_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             inc_i,
  output logic             spent_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_eff;
  logic             lim_en, cnt_en;

  assign lim_eff = (lim_q == '0) ? ONE : lim_q;

  always_comb begin
    lim_en = load_i;
    lim_d  = lim_i;
    cnt_en = load_i | inc_i;
    cnt_d  = load_i ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      cnt_q <= '0;
    end else begin
      if (lim_en) lim_q <= lim_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign spent_o = (cnt_q >= lim_eff);

  // R9
  poll_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_eff);

  // R9
  no_inc_when_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> !spent_o);

endmodule

// File: rtl/cardinit_ocr_win.sv
module cardinit_ocr_win #(
  parameter int DATA_W = 32,
  parameter int WIN_LO = 15,
  parameter int WIN_HI = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [WIN_HI-WIN_LO:0]   mask_i,
  input  logic [DATA_W-1:0]        ocr_i,
  output logic                     fit_o
);

  localparam int WIN_W = WIN_HI - WIN_LO + 1;

  logic [WIN_W-1:0] mask_q;
  logic [WIN_W-1:0] common;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (load_i) mask_q <= mask_i;
  end

  for (genvar b = 0; b < WIN_W; b++) begin : g_win
    assign common[b] = ocr_i[WIN_LO + b] & mask_q[b];
  end

  assign fit_o = |common;

endmodule

// File: rtl/cardinit_seq.sv
module cardinit_seq
  import cardinit_pkg::*;
#(
  parameter int RETRY_W   = 16,
  parameter int WAKE_CLKS = 80,
  parameter int WIN_LO    = 15,
  parameter int WIN_HI    = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   ocr_chk_en_i,
  input  logic [WIN_HI-WIN_LO:0] volt_mask_i,
  input  logic [RETRY_W-1:0]     retry_lim_i,
  output logic                   wake_req_o,
  output logic [7:0]             wake_clks_o,
  output logic                   cmd_valid_o,
  output logic [5:0]             cmd_index_o,
  output logic [31:0]            cmd_arg_o,
  output logic [7:0]             cmd_crc_o,
  input  logic                   lnk_done_i,
  input  logic [7:0]             rsp_r1_i,
  input  logic [31:0]            rsp_data_i,
  output logic                   busy_o,
  output logic                   ready_o,
  output logic                   volt_err_o,
  output logic                   tmo_err_o,
  output logic                   rsp_err_o
);

  localparam logic [7:0] WAKE_CNT = 8'(WAKE_CLKS);

  seq_state_e state_q, state_d;
  result_e    res_q, res_d;
  logic       res_vld_q, res_vld_d;
  logic       ocr_en_q;
  logic       accept;
  logic       fin;
  result_e    fin_code;
  logic       r1_err;
  logic       win_fit;
  logic       spent;
  cmd_kind_e  kind;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign r1_err = |rsp_r1_i[7:1];

  // next-state process
  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_code = RES_READY;
    unique case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_WAKE_REQ;
      ST_WAKE_REQ:  state_d = ST_WAKE_WAIT;
      ST_WAKE_WAIT: if (lnk_done_i) state_d = ST_RST_REQ;
      ST_RST_REQ:   state_d = ST_RST_WAIT;
      ST_RST_WAIT: begin
        if (lnk_done_i) begin
          if (r1_err) begin
            fin = 1'b1; fin_code = RES_RSP;
          end else begin
            state_d = ocr_en_q ? ST_OCR_REQ : ST_POLL_REQ;
          end
        end
      end
      ST_OCR_REQ:   state_d = ST_OCR_WAIT;
      ST_OCR_WAIT: begin
        if (lnk_done_i) begin
          if (r1_err) begin
            fin = 1'b1; fin_code = RES_RSP;
          end else if (!win_fit) begin
            fin = 1'b1; fin_code = RES_VOLT;
          end else begin
            state_d = ST_POLL_REQ;
          end
        end
      end
      ST_POLL_REQ:  state_d = ST_POLL_WAIT;
      ST_POLL_WAIT: begin
        if (lnk_done_i) begin
          if (r1_err) begin
            fin = 1'b1; fin_code = RES_RSP;
          end else if (!rsp_r1_i[0]) begin
            fin = 1'b1; fin_code = RES_READY;
          end else if (spent) begin
            fin = 1'b1; fin_code = RES_TMO;
          end else begin
            state_d = ST_POLL_REQ;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  always_comb begin
    res_vld_d = res_vld_q;
    res_d     = res_q;
    if (accept) begin
      res_vld_d = 1'b0;
    end else if (fin) begin
      res_vld_d = 1'b1;
      res_d     = fin_code;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      res_q     <= RES_READY;
      res_vld_q <= 1'b0;
      ocr_en_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      res_q     <= res_d;
      res_vld_q <= res_vld_d;
      if (accept) ocr_en_q <= ocr_chk_en_i;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_RST_REQ:  kind = CK_GO_IDLE;
      ST_OCR_REQ:  kind = CK_READ_OCR;
      ST_POLL_REQ: kind = CK_OP_COND;
      default:     kind = CK_NONE;
    endcase
  end

  cardinit_cmd_fmt #(.ARG_W(32)) fmt_i (
    .kind_i  (kind),
    .index_o (cmd_index_o),
    .arg_o   (cmd_arg_o),
    .crc_o   (cmd_crc_o)
  );

  cardinit_retry_ctr #(.CNT_W(RETRY_W)) retry_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .lim_i   (retry_lim_i),
    .inc_i   (state_q == ST_POLL_REQ),
    .spent_o (spent)
  );

  cardinit_ocr_win #(.DATA_W(32), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) win_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .mask_i (volt_mask_i),
    .ocr_i  (rsp_data_i),
    .fit_o  (win_fit)
  );

  assign wake_req_o  = (state_q == ST_WAKE_REQ);
  assign wake_clks_o = WAKE_CNT;
  assign cmd_valid_o = (kind != CK_NONE);
  assign busy_o      = (state_q != ST_IDLE);
  assign ready_o     = res_vld_q && (res_q == RES_READY);
  assign volt_err_o  = res_vld_q && (res_q == RES_VOLT);
  assign tmo_err_o   = res_vld_q && (res_q == RES_TMO);
  assign rsp_err_o   = res_vld_q && (res_q == RES_RSP);

  // R2
  wake_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_req_o && cmd_valid_o));

  // R2
  wake_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> wake_req_o);

  // R3
  reset_cmd_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_index_o == 6'd0) |-> (cmd_crc_o == 8'h95 && cmd_arg_o == 32'd0));

  // R6
  poll_no_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_index_o == 6'd1) |-> cmd_arg_o == 32'd0);

  // R7
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(lnk_done_i && rsp_r1_i == 8'h00));

  // R8
  rsp_err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_err_o) |-> $past(lnk_done_i && rsp_r1_i[7:1] != 7'd0));

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !lnk_done_i) |=> !wake_req_o);

  // R11
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready_o, volt_err_o, tmo_err_o, rsp_err_o}));

  // R11
  busy_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !(ready_o || volt_err_o || tmo_err_o || rsp_err_o));

endmodule

// File: tb/cardinit_seq_tb.sv
module cardinit_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        ocr_chk_en_i;
  logic [8:0]  volt_mask_i;
  logic [15:0] retry_lim_i;
  logic        wake_req_o;
  logic [7:0]  wake_clks_o;
  logic        cmd_valid_o;
  logic [5:0]  cmd_index_o;
  logic [31:0] cmd_arg_o;
  logic [7:0]  cmd_crc_o;
  logic        lnk_done_i;
  logic [7:0]  rsp_r1_i;
  logic [31:0] rsp_data_i;
  logic        busy_o, ready_o, volt_err_o, tmo_err_o, rsp_err_o;

  int n_chk;
  int n_fail;

  cardinit_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ocr_chk_en_i(ocr_chk_en_i),
    .volt_mask_i(volt_mask_i), .retry_lim_i(retry_lim_i),
    .wake_req_o(wake_req_o), .wake_clks_o(wake_clks_o),
    .cmd_valid_o(cmd_valid_o), .cmd_index_o(cmd_index_o),
    .cmd_arg_o(cmd_arg_o), .cmd_crc_o(cmd_crc_o),
    .lnk_done_i(lnk_done_i), .rsp_r1_i(rsp_r1_i), .rsp_data_i(rsp_data_i),
    .busy_o(busy_o), .ready_o(ready_o), .volt_err_o(volt_err_o),
    .tmo_err_o(tmo_err_o), .rsp_err_o(rsp_err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // result codes: 0 ready, 1 voltage, 2 timeout, 3 response error
  function automatic int poll_rsp(input int i, input int p, input int e, input logic [7:0] er);
    if (i == e) return int'(er);
    if (i <= p) return 1;
    return 0;
  endfunction

  function automatic void predict(
    input bit oen, input logic [31:0] ocr, input logic [8:0] msk,
    input logic [7:0] r0, input logic [7:0] ro, input int p, input int e,
    input logic [7:0] er, input int lim,
    output int res, output int n1, output int n58);
    int lmax;
    int r;
    lmax = (lim == 0) ? 1 : lim;
    n1 = 0; n58 = 0; res = 0;
    if (r0[7:1] != 0) begin res = 3; return; end
    if (oen) begin
      n58 = 1;
      if (ro[7:1] != 0) begin res = 3; return; end
      if ((ocr[23:15] & msk) == 0) begin res = 1; return; end
    end
    for (int i = 1; i < 100000; i++) begin
      n1 = i;
      r = poll_rsp(i, p, e, er);
      if (r[7:1] != 0) begin res = 3; return; end
      if (r[0] == 1'b0) begin res = 0; return; end
      if (i >= lmax) begin res = 2; return; end
    end
  endfunction

  task automatic run_case(
    input string nm, input bit oen, input logic [31:0] ocr, input logic [8:0] msk,
    input logic [7:0] r0, input logic [7:0] ro, input int p, input int e,
    input logic [7:0] er, input int lim, input bit mid_start, input bit cfg_change);
    int exp_res, exp_n1, exp_n58;
    int n1, n58, nw, ev, ord_bad, fmt_bad, guard, d, res;
    n1 = 0; n58 = 0; nw = 0; ev = 0; ord_bad = 0; fmt_bad = 0; guard = 0;
    predict(oen, ocr, msk, r0, ro, p, e, er, lim, exp_res, exp_n1, exp_n58);
    ocr_chk_en_i = oen; volt_mask_i = msk; retry_lim_i = 16'(lim);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    if (cfg_change) begin
      // R12: altered after acceptance
      ocr_chk_en_i = ~oen; volt_mask_i = ~msk; retry_lim_i = 16'(lim + 7);
    end
    while (busy_o && guard < 5000) begin
      if (wake_req_o || cmd_valid_o) begin
        ev++;
        rsp_r1_i = 8'h00; rsp_data_i = 32'h0;
        if (wake_req_o) begin
          nw++;
          if (ev != 1) ord_bad++;
          if (wake_clks_o < 74) fmt_bad++;
        end else begin
          if (cmd_arg_o != 32'd0) fmt_bad++;
          case (cmd_index_o)
            6'd0: begin
              if (ev != 2) ord_bad++;
              if (cmd_crc_o != 8'h95) fmt_bad++;
              rsp_r1_i = r0;
            end
            6'd58: begin
              n58++;
              if (ev != 3) ord_bad++;
              rsp_r1_i = ro; rsp_data_i = ocr;
            end
            6'd1: begin
              n1++;
              if (ev < 3) ord_bad++;
              rsp_r1_i = 8'(poll_rsp(n1, p, e, er));
              rsp_data_i = $urandom;
            end
            default: ord_bad++;
          endcase
        end
        d = 1 + int'($urandom % 4);
        start_i = mid_start;  // R10: pulse while waiting
        @(negedge clk); start_i = 1'b0; guard++;
        repeat (d - 1) begin @(negedge clk); guard++; end
        lnk_done_i = 1'b1;
        @(negedge clk); guard++;
        lnk_done_i = 1'b0;
      end else begin
        @(negedge clk); guard++;
      end
    end
    chk({nm, " watchdog"}, guard < 5000 ? 1 : 0, 1);
    res = ready_o ? 0 : volt_err_o ? 1 : tmo_err_o ? 2 : rsp_err_o ? 3 : 9;
    chk({nm, " R5/R7/R8/R9 result"}, res, exp_res);
    chk({nm, " R11 flag count"}, int'(ready_o) + int'(volt_err_o) + int'(tmo_err_o) + int'(rsp_err_o), 1);
    chk({nm, " R6/R9 poll count"}, n1, exp_n1);
    chk({nm, " R4 register reads"}, n58, exp_n58);
    chk({nm, " R2/R10 wake count"}, nw, 1);
    chk({nm, " R2/R3 order"}, ord_bad, 0);
    chk({nm, " R3/R6 format"}, fmt_bad, 0);
    repeat (2) @(negedge clk);
    chk({nm, " R11 idle after run"}, int'(busy_o), 0);
  endtask

  initial begin
    int ntr, e, p;
    logic [7:0] r0, ro, er;
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd20240917));
    rst_n = 1'b0; start_i = 1'b0; ocr_chk_en_i = 1'b0; volt_mask_i = '0;
    retry_lim_i = '0; lnk_done_i = 1'b0; rsp_r1_i = '0; rsp_data_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", int'({busy_o, ready_o, volt_err_o, tmo_err_o, rsp_err_o,
                                  wake_req_o, cmd_valid_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", int'({busy_o, ready_o, volt_err_o, tmo_err_o, rsp_err_o,
                                  wake_req_o, cmd_valid_o}), 0);

    // directed corner cases
    run_case("R7 immediate", 1'b0, 32'h0, 9'h1FF, 8'h01, 8'h01, 0, -1, 8'h00, 5, 1'b0, 1'b0);
    run_case("R9 limit hit", 1'b0, 32'h0, 9'h1FF, 8'h01, 8'h01, 3, -1, 8'h00, 3, 1'b0, 1'b0);
    run_case("R9 limit clear", 1'b0, 32'h0, 9'h1FF, 8'h01, 8'h01, 3, -1, 8'h00, 4, 1'b0, 1'b0);
    run_case("R9 zero limit", 1'b0, 32'h0, 9'h1FF, 8'h01, 8'h01, 1, -1, 8'h00, 0, 1'b0, 1'b0);
    run_case("R9 zero ready", 1'b0, 32'h0, 9'h1FF, 8'h01, 8'h01, 0, -1, 8'h00, 0, 1'b0, 1'b0);
    run_case("R5 window miss", 1'b1, 32'h00FF_0000, 9'h001, 8'h01, 8'h01, 0, -1, 8'h00, 4, 1'b0, 1'b0);
    run_case("R5 low edge", 1'b1, 32'h0000_8000, 9'h001, 8'h01, 8'h01, 1, -1, 8'h00, 4, 1'b0, 1'b0);
    run_case("R5 high edge", 1'b1, 32'h0080_0000, 9'h100, 8'h01, 8'h01, 1, -1, 8'h00, 4, 1'b0, 1'b0);
    run_case("R5 below window", 1'b1, 32'h0000_4000, 9'h1FF, 8'h01, 8'h01, 0, -1, 8'h00, 4, 1'b0, 1'b0);
    run_case("R4 check off", 1'b0, 32'h0000_0000, 9'h000, 8'h01, 8'hFE, 0, -1, 8'h00, 4, 1'b0, 1'b0);
    run_case("R8 reset rsp", 1'b1, 32'h00FF_8000, 9'h1FF, 8'h05, 8'h01, 0, -1, 8'h00, 4, 1'b0, 1'b0);
    run_case("R8 ocr rsp", 1'b1, 32'h00FF_8000, 9'h1FF, 8'h01, 8'h41, 0, -1, 8'h00, 4, 1'b0, 1'b0);
    run_case("R8 poll rsp", 1'b1, 32'h00FF_8000, 9'h1FF, 8'h01, 8'h01, 5, 3, 8'h81, 9, 1'b0, 1'b0);
    run_case("R10 stray start", 1'b1, 32'h00FF_8000, 9'h1FF, 8'h01, 8'h01, 2, -1, 8'h00, 9, 1'b1, 1'b0);
    run_case("R12 cfg change", 1'b1, 32'h0000_8000, 9'h001, 8'h01, 8'h01, 2, -1, 8'h00, 2, 1'b0, 1'b1);

    // random cases
    for (int t = 0; t < 40; t++) begin
      p  = int'($urandom % 7);
      e  = (($urandom % 4) == 0) ? 1 + int'($urandom % 8) : -1;
      r0 = (($urandom % 8) == 0) ? (8'h01 | (8'h1 << (1 + $urandom % 7))) : 8'h01;
      ro = (($urandom % 8) == 0) ? (8'h01 | (8'h1 << (1 + $urandom % 7))) : 8'h01;
      er = 8'h01 | (8'h1 << (1 + $urandom % 7));
      ntr = int'($urandom % 9);
      run_case($sformatf("rand%0d", t), 1'($urandom), $urandom, 9'($urandom), r0, ro,
               p, e, er, ntr, 1'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule